// File: doc/BRIEF.md
# Bidirectional I/O port with change detection

The block is one general-purpose I/O port of a configurable width. Each pin has an output latch and a direction bit. Software writes the latch and the direction register over a simple strobe bus and reads either the live pin levels or the direction register back. The pad logic receives the latch value, a per-pin output enable and a per-pin weak pull-up enable.

The upper pins of the port, from `IOC_LO` to the top bit, carry change detection. Each such pin that is an input is compared against a snapshot of its level. Any difference raises a sticky change flag, which goes to an external interrupt controller as a level. Each read or write of the port data register takes a fresh snapshot, so a read of the port is how an interrupt handler ends the mismatch before it clears the flag.

Top module: `gpio_ioc_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, every direction bit becomes 1, the output latch becomes 0, the change flag becomes 0 and the pull-up control becomes disabled. Afterwards `pin_oe` is all 0, `pin_out` is all 0, `chg_flag` is 0 and `pin_pu` is all 0.
- R2: A clock edge with `dir_wr` high loads `wdata` into the direction register. From then on `pin_oe[i]` is the inverse of direction bit i: 1 = input, and 0 = driven. A `dir_rd` with `data_rd` low returns the direction register on `rdata` in the same cycle.
- R3: A clock edge with `data_wr` high loads `wdata` into the output latch, which appears on `pin_out`. The direction register is not changed.
- R4: `rdata` is combinational. With `data_rd` high it equals `pin_in`, whatever `dir_rd` is. With `dir_rd` high alone it is the direction register. With neither it is 0.
- R5: At a clock edge where a pin in `IOC_LO`..`WIDTH-1` is an input, its `pin_in` level differs from its snapshot, and neither `data_rd` nor `data_wr` is high, `chg_flag` becomes 1.
- R6: Pins below `IOC_LO`, and pins in the upper group whose direction bit is 0, never set the flag.
- R7: `chg_flag` stays 1 until an edge with `flag_clr` high at which no mismatch sets it. While the mismatch persists, setting wins over clearing.
- R8: At every edge with `data_rd` or `data_wr` high, the snapshot of the upper pins is reloaded from `pin_in`, and the comparison does not set the flag at that edge. A change that appears in the same cycle as a read is therefore taken into the snapshot without setting the flag.
- R9: The pull-up control register takes the inverse of the active-low `pullup_en_n` at each edge out of reset. `pin_pu[i]` is 1 only when that control is enabled and pin i is an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | WIDTH | Levels sensed at the pins |
| data_wr | input | 1 | Write strobe for the output latch |
| dir_wr | input | 1 | Write strobe for the direction register |
| data_rd | input | 1 | Read strobe for the pin levels |
| dir_rd | input | 1 | Read strobe for the direction register |
| wdata | input | WIDTH | Write data |
| pullup_en_n | input | 1 | Global pull-up enable, active low |
| flag_clr | input | 1 | Change-flag clear strobe |
| pin_out | output | WIDTH | Output latch value to the pads |
| pin_oe | output | WIDTH | Per-pin output enable, 1 = driven |
| pin_pu | output | WIDTH | Per-pin weak pull-up enable |
| rdata | output | WIDTH | Read data |
| chg_flag | output | 1 | Latched change flag |

## Verification
The bench builds the block with the defaults, `WIDTH` = 8 and `IOC_LO` = 4, so four pins have change detection. That brings all 16 direction settings of the detected pins, crossed with all 16 toggle masks, into a full sweep. In every case the lower pins toggle too, and the expected flag is the OR of the toggle mask ANDed with the direction bits. Directed sequences cover set-over-clear, a change absorbed by a read in the same cycle, the read-select priority and the pull-up gating.

// File: rtl/gpio_ioc_pkg.sv
// Shared types of the I/O port: the read-data source selection.
package gpio_ioc_pkg;
    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_PINS = 2'd1,
        RSEL_DIR  = 2'd2
    } rd_sel_e;
endpackage

// File: rtl/gpio_dir_latch.sv
// Holds the direction register and the output latch of the port.
// Assumes one write strobe per register; both may be high in one cycle.
module gpio_dir_latch #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_wr,
    input  logic             dir_wr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] latch_q
);
    // Direction register: all pins are inputs after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '1;
        else if (dir_wr) dir_q <= wdata;
    end

    // Output latch: written only by port data writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       latch_q <= '0;
        else if (data_wr) latch_q <= wdata;
    end

    a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr |=> dir_q == $past(wdata));
    a_r3_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> latch_q == $past(wdata));
    a_r3_dir_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !dir_wr) |=> $stable(dir_q));
endmodule

// File: rtl/gpio_pullup.sv
// Registered global pull-up control and per-pin gating by direction.
// Assumes the enable input is active low; pull-ups are off out of reset.
module gpio_pullup #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pullup_en_n,
    input  logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] pin_pu
);
    logic pu_on;

    // Pull-up control register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pu_on <= 1'b0;
        else        pu_on <= ~pullup_en_n;
    end

    // A pull-up is only offered on pins that are inputs.
    always_comb pin_pu = {WIDTH{pu_on}} & dir_q;
endmodule

// File: rtl/gpio_change_det.sv
// Change detection on the upper pins against a snapshot refreshed by each
// port access, with a sticky flag where setting wins over clearing.
// Assumes pins are already synchronised to clk.
module gpio_change_det #(
    parameter int NIOC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIOC-1:0] pins,
    input  logic [NIOC-1:0] dir_in,
    input  logic            refresh,
    input  logic            flag_clr,
    output logic            flag
);
    logic [NIOC-1:0] snap;
    logic [NIOC-1:0] mism;
    logic            set_now;

    // Per-pin mismatch on inputs only; a port access masks the comparison.
    always_comb begin
        mism    = (pins ^ snap) & dir_in;
        set_now = (|mism) && !refresh;
    end

    // Snapshot follows the pins during reset and on every port access.
    always_ff @(posedge clk) begin
        if (!rst_n || refresh) snap <= pins;
    end

    // Sticky flag: set has priority over the clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (set_now)  flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    a_r5_mismatch_sets: assert property (@(posedge clk) disable iff (!rst_n)
        set_now |=> flag);
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);
    a_r7_clear_wins_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && refresh) |=> !flag);
    a_r8_refresh_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh && !flag) |=> !flag);
endmodule

// File: rtl/gpio_ioc_port.sv
// Top of the I/O port: registers, pull-up gating, change detection and
// read-data selection. Assumes pin_in is synchronous to clk.
module gpio_ioc_port
    import gpio_ioc_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int IOC_LO = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    input  logic             data_wr,
    input  logic             dir_wr,
    input  logic             data_rd,
    input  logic             dir_rd,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pullup_en_n,
    input  logic             flag_clr,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_pu,
    output logic [WIDTH-1:0] rdata,
    output logic             chg_flag
);
    localparam int NIOC = WIDTH - IOC_LO;

    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] latch_q;
    rd_sel_e          rsel;

    gpio_dir_latch #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .dir_wr(dir_wr),
        .wdata(wdata), .dir_q(dir_q), .latch_q(latch_q)
    );

    gpio_pullup #(.WIDTH(WIDTH)) u_pu (
        .clk(clk), .rst_n(rst_n), .pullup_en_n(pullup_en_n),
        .dir_q(dir_q), .pin_pu(pin_pu)
    );

    gpio_change_det #(.NIOC(NIOC)) u_chg (
        .clk(clk), .rst_n(rst_n),
        .pins(pin_in[WIDTH-1:IOC_LO]), .dir_in(dir_q[WIDTH-1:IOC_LO]),
        .refresh(data_rd || data_wr), .flag_clr(flag_clr), .flag(chg_flag)
    );

    // Pad drive: latch out, enable where the direction bit is 0.
    always_comb begin
        pin_out = latch_q;
        pin_oe  = ~dir_q;
    end

    // Read source selection: pin levels take priority over direction.
    always_comb begin
        if (data_rd)     rsel = RSEL_PINS;
        else if (dir_rd) rsel = RSEL_DIR;
        else             rsel = RSEL_NONE;
    end

    // Read data multiplexer.
    always_comb begin
        case (rsel)
            RSEL_PINS: rdata = pin_in;
            RSEL_DIR:  rdata = dir_q;
            default:   rdata = '0;
        endcase
    end

    a_r4_read_pins: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd |-> rdata == pin_in);
    a_r9_pu_only_inputs: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & pin_oe) == '0);
    a_r1_flag_after_reset: assert property (@(posedge clk)
        !rst_n |=> !chg_flag);
endmodule

// File: tb/gpio_ioc_port_tb.sv
module gpio_ioc_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pin_in = '0;
    logic         data_wr = 0, dir_wr = 0, data_rd = 0, dir_rd = 0;
    logic [W-1:0] wdata = '0;
    logic         pullup_en_n = 1'b0;
    logic         flag_clr = 1'b0;
    logic [W-1:0] pin_out, pin_oe, pin_pu, rdata;
    logic         chg_flag;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    gpio_ioc_port #(.WIDTH(W), .IOC_LO(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .data_wr(data_wr),
        .dir_wr(dir_wr), .data_rd(data_rd), .dir_rd(dir_rd), .wdata(wdata),
        .pullup_en_n(pullup_en_n), .flag_clr(flag_clr), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_pu(pin_pu), .rdata(rdata), .chg_flag(chg_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_dir(input logic [W-1:0] d);
        dir_wr = 1; wdata = d; cyc(); dir_wr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        pin_in = 8'hA5;
        repeat (3) cyc();
        chk("R1 oe", pin_oe, 8'h00);
        chk("R1 out", pin_out, 8'h00);
        chk("R1 pu", pin_pu, 8'h00);
        chk("R1 flag", {7'd0, chg_flag}, 8'h00);
        rst_n = 1; cyc();
        // R9 pull-ups enabled on all inputs one edge after release
        chk("R9 pu all inputs", pin_pu, 8'hFF);

        // R2 direction write and readback
        set_dir(8'h0F);
        chk("R2 oe", pin_oe, 8'hF0);
        chk("R9 pu follows dir", pin_pu, 8'h0F);
        dir_rd = 1; #1;
        chk("R2 dir readback", rdata, 8'h0F);
        // R4 pin read has priority over direction read
        data_rd = 1; pin_in = 8'h3C; #1;
        chk("R4 priority", rdata, 8'h3C);
        dir_rd = 0; #1;
        chk("R4 pins", rdata, 8'h3C);
        cyc(); data_rd = 0; #1;
        chk("R4 idle zero", rdata, 8'h00);

        // R3 data write keeps direction
        data_wr = 1; wdata = 8'h96; cyc(); data_wr = 0;
        chk("R3 out", pin_out, 8'h96);
        chk("R3 dir kept", pin_oe, 8'hF0);
        pullup_en_n = 1; cyc();
        chk("R9 pu off", pin_pu, 8'h00);

        // Exhaustive sweep: direction of upper pins x toggle mask (R5 R6)
        for (int dh = 0; dh < 16; dh++) begin
            for (int m = 0; m < 16; m++) begin
                logic [W-1:0] base;
                logic         expf;
                base = 8'h5A ^ W'(dh * 17) ^ W'(m);
                set_dir({dh[3:0], 4'hF});
                pin_in = base; data_wr = 1; wdata = 8'h00; flag_clr = 1;
                cyc(); data_wr = 0; flag_clr = 0;
                chk("R8 write refresh clears", {7'd0, chg_flag}, 8'h00);
                pin_in = base ^ {m[3:0], 4'hF};
                cyc();
                expf = |(m[3:0] & dh[3:0]);
                chk(expf ? "R5 change sets" : "R6 excluded", {7'd0, chg_flag}, {7'd0, expf});
                data_rd = 1; cyc(); data_rd = 0;
                flag_clr = 1; cyc(); flag_clr = 0;
                chk("R7 clear after read", {7'd0, chg_flag}, 8'h00);
            end
        end

        // R7 set wins while the mismatch persists
        set_dir(8'hFF);
        pin_in = 8'h00; data_rd = 1; cyc(); data_rd = 0;
        pin_in = 8'h10; cyc();
        chk("R7 set", {7'd0, chg_flag}, 8'h01);
        flag_clr = 1; cyc(); flag_clr = 0;
        chk("R7 set wins", {7'd0, chg_flag}, 8'h01);
        cyc();
        chk("R7 sticky", {7'd0, chg_flag}, 8'h01);
        data_rd = 1; cyc(); data_rd = 0;
        flag_clr = 1; cyc(); flag_clr = 0;
        chk("R7 cleared", {7'd0, chg_flag}, 8'h00);

        // R8 change coinciding with a read is absorbed
        pin_in = 8'h90; data_rd = 1; cyc(); data_rd = 0;
        cyc();
        chk("R8 read absorbs change", {7'd0, chg_flag}, 8'h00);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule